// File: doc/BRIEF.md
# Keyed System Reset Controller

This block gathers every request that can restart the system-on-chip and turns them into a small set of reset outputs. The requests come from several places. There is an active-low power-on pin and an active-low system reset pin. A mode pin chooses between a plain system restart and a post-mortem restart. The fabric side can raise two active-low requests, but they only count when its 3-bit enable input is all ones. A mode register carries trigger bits, and a write to it takes effect only when its upper half holds a fixed key.

The outputs are a reset for the clock-manager domain, a system reset, a fabric-side reset, a hold for the DDR controller core and one halt control per core. Each core also has a status word that records what caused the last reset: the kind of reset and where the request came from. When more than one request is active, the controller records only the widest one.

A post-mortem restart keeps the debug settings: the halt-after-post-mortem flag and the per-core mode words. Software can then inspect a failed system with the cores held. Every release is synchronous to the clock. A reset raised from a register bit lasts a fixed number of cycles, set by a parameter.

Top module: `soc_reset_hub`

## Requirements
- R1: A write to word address 0 (mode register) changes state or triggers a reset only when bits 31:16 equal 0xCDEF. Bits 31:16 always read as zero.
- R2: In a keyed write, bit 0 requests a power-on reset, bit 1 a system reset and bit 2 a post-mortem reset. A 0 in these bits does nothing, and bits 2:0 always read as zero.
- R3: `clkmgr_rst_n` goes low only for a power-on class reset. A system or post-mortem reset leaves it high.
- R4: While the synchronised `sys_pin_n` is low, the block raises a system reset if `pm_mode_pin` is 0 and a post-mortem reset if it is 1.
- R5: A power-on or system reset restores the defaults. Mode register bit 3 returns to 0 and bit 4 to 1 (read value 0x10). Core 0's mode word returns to {0, tcm 0, halt CORE0_HALT}, and the other cores' words to 0x3. A post-mortem reset leaves all of these unchanged.
- R6: If mode bit 3 is 1 when a post-mortem reset occurs, all `core_halt` bits stay 1 until bit 3 is cleared. Otherwise `core_halt[i]` follows bit 0 of core i's mode word (word address 1+i).
- R7: `fab_sys_req_n` and `fab_pm_req_n` take effect only when `fab_en` equals 3'b111.
- R8: The status word of core i is at word address 1+NCORE+i. Bits 4:2 hold the source: 0 pin, 1 power-on bit, 3 system bit, 4 post-mortem bit, 5 warm, 6 fabric. Bits 1:0 hold the type: 0 power-on, 1 system, 2 post-mortem, 3 warm.
- R9: `fab_rst_n` is low whenever a power-on, system or post-mortem reset is active.
- R10: `ddrc_rst` equals mode register bit 4.
- R11: A register-triggered reset drives `sys_rst_n` low from the clock edge that takes the write for exactly STRETCH cycles. Any reset stays active for at least STRETCH cycles after its last request.
- R12: Among requests active in the same cycle, the recorded cause is chosen by type first: power-on, then system, then post-mortem. Within one type the order is pin, then register bit, then fabric.
- R13: Register writes are ignored while any reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, running during every reset |
| por_pin_n | input | 1 | Power-on pin, active low, asynchronous assert |
| sys_pin_n | input | 1 | System reset pin, active low, synchronised inside |
| pm_mode_pin | input | 1 | 1 selects post-mortem for the system pin |
| fab_en | input | 3 | Fabric request enable, active only when all ones |
| fab_sys_req_n | input | 1 | Fabric system reset request, active low |
| fab_pm_req_n | input | 1 | Fabric post-mortem request, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| clkmgr_rst_n | output | 1 | Clock-manager domain reset, active low |
| sys_rst_n | output | 1 | System reset, active low |
| fab_rst_n | output | 1 | Fabric-side reset, active low |
| core_halt | output | NCORE | Per-core halt control |
| ddrc_rst | output | 1 | DDR controller core reset hold |

## Verification
A keyed write or a gated fabric request acts at the edge that samples it. The reset outputs and the status word are therefore valid at the next falling edge, and that is where the bench samples them. A pin request first crosses SYNC_STAGES flops and takes effect one edge later, so the bench holds pins low for several cycles before it samples. Release comes STRETCH edges after the last request. The bench waits STRETCH plus a margin before it checks that the outputs are free, and it counts the exact low width of one register-triggered reset.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;

   typedef enum logic [1:0] {
      RT_POR  = 2'd0,
      RT_SYS  = 2'd1,
      RT_PM   = 2'd2,
      RT_WARM = 2'd3
   } rst_type_e;

   typedef enum logic [2:0] {
      RS_PIN     = 3'd0,
      RS_REG_POR = 3'd1,
      RS_REG_SYS = 3'd3,
      RS_REG_PM  = 3'd4,
      RS_WARM    = 3'd5,
      RS_FABRIC  = 3'd6
   } rst_src_e;

   typedef struct packed {
      rst_src_e  src;
      rst_type_e kind;
   } rst_cause_t;

   // mode register bit positions decoded by the trigger logic
   localparam int unsigned MB_POR     = 0;
   localparam int unsigned MB_SYS     = 1;
   localparam int unsigned MB_PM      = 2;
   localparam int unsigned MB_PMHALT  = 3;
   localparam int unsigned MB_DDRC    = 4;
   localparam int unsigned KEY_LSB    = 16;
   localparam int unsigned VEC_LSB    = 5;
   localparam int unsigned DATA_W     = 32;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rst_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sh_q <= {STAGES{RST_VAL}};
      else         sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/rst_cause_arb.sv
module rst_cause_arb
   import rst_hub_pkg::*;
#(
   parameter int unsigned FAB_EN_W = 3
) (
   input  logic                pin_act,
   input  logic                pin_pm_sel,
   input  logic [2:0]          reg_trig,
   input  logic [FAB_EN_W-1:0] fab_en,
   input  logic                fab_sys,
   input  logic                fab_pm,
   output logic                hit,
   output rst_type_e           hit_kind,
   output rst_src_e            hit_src
);

   localparam logic [FAB_EN_W-1:0] FAB_ON = {FAB_EN_W{1'b1}};

   logic fab_open, pin_sys, pin_pm, fsys, fpm;

   assign fab_open = (fab_en == FAB_ON);
   assign fsys     = fab_open & fab_sys;
   assign fpm      = fab_open & fab_pm;
   assign pin_sys  = pin_act & ~pin_pm_sel;
   assign pin_pm   = pin_act &  pin_pm_sel;

   // widest type first, then pin, register bit, fabric
   always_comb begin
      hit      = 1'b1;
      hit_kind = RT_POR;
      hit_src  = RS_REG_POR;
      if (reg_trig[MB_POR]) begin
         hit_kind = RT_POR;
         hit_src  = RS_REG_POR;
      end else if (pin_sys) begin
         hit_kind = RT_SYS;
         hit_src  = RS_PIN;
      end else if (reg_trig[MB_SYS]) begin
         hit_kind = RT_SYS;
         hit_src  = RS_REG_SYS;
      end else if (fsys) begin
         hit_kind = RT_SYS;
         hit_src  = RS_FABRIC;
      end else if (pin_pm) begin
         hit_kind = RT_PM;
         hit_src  = RS_PIN;
      end else if (reg_trig[MB_PM]) begin
         hit_kind = RT_PM;
         hit_src  = RS_REG_PM;
      end else if (fpm) begin
         hit_kind = RT_PM;
         hit_src  = RS_FABRIC;
      end else begin
         hit = 1'b0;
      end
   end

endmodule

// File: rtl/rst_stretch.sv
module rst_stretch
   import rst_hub_pkg::*;
#(
   parameter int unsigned STRETCH = 16
) (
   input  logic      clk,
   input  logic      arst_n,
   input  logic      hit,
   input  rst_type_e hit_kind,
   output logic      active,
   output rst_type_e active_kind
);

   localparam int unsigned     CNT_W = (STRETCH < 2) ? 1 : $clog2(STRETCH + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);

   logic [CNT_W-1:0] cnt_q;
   rst_type_e        kind_q;
   logic             busy;

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q  <= LOAD;
         kind_q <= RT_POR;
      end else if (hit) begin
         cnt_q  <= LOAD;
         kind_q <= (busy && (kind_q < hit_kind)) ? kind_q : hit_kind;
      end else if (busy) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign active      = busy;
   assign active_kind = kind_q;

endmodule

// File: rtl/rst_mode_regs.sv
module rst_mode_regs
   import rst_hub_pkg::*;
#(
   parameter int unsigned NCORE      = 4,
   parameter int unsigned ADDR_W     = 4,
   parameter logic [15:0] KEY        = 16'hCDEF,
   parameter logic        CORE0_HALT = 1'b0
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              wr_block,
   input  logic              dflt,
   input  logic              pm_hit,
   input  logic              cause_we,
   input  rst_cause_t        cause_in,
   output logic [2:0]        trig,
   output logic              ddrc,
   output logic [NCORE-1:0]  halt_out
);

   localparam int unsigned CORE_BASE = 1;
   localparam int unsigned STAT_BASE = 1 + NCORE;
   localparam int unsigned VEC_W     = DATA_W - VEC_LSB;

   logic keyed, wr_ok, pm_halt_q, ddrc_q, halt_all_q, pm_halt_eff;
   logic [DATA_W-1:0] rd_core [NCORE];

   assign wr_ok       = we & ~wr_block;
   assign keyed       = wr_ok && (addr == '0) && (wdata[DATA_W-1:KEY_LSB] == KEY);
   assign trig        = keyed ? wdata[MB_PM:MB_POR] : 3'b000;
   assign pm_halt_eff = keyed ? wdata[MB_PMHALT] : pm_halt_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         pm_halt_q <= 1'b0;
         ddrc_q    <= 1'b1;
      end else if (dflt) begin
         pm_halt_q <= 1'b0;
         ddrc_q    <= 1'b1;
      end else if (keyed) begin
         pm_halt_q <= wdata[MB_PMHALT];
         ddrc_q    <= wdata[MB_DDRC];
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                    halt_all_q <= 1'b0;
      else if (dflt)                  halt_all_q <= 1'b0;
      else if (pm_hit && pm_halt_eff) halt_all_q <= 1'b1;
      else if (!pm_halt_q)            halt_all_q <= 1'b0;
   end

   assign ddrc = ddrc_q;

   for (genvar i = 0; i < NCORE; i++) begin : g_core
      localparam logic HALT_D = (i == 0) ? CORE0_HALT : 1'b1;
      localparam logic TCM_D  = (i != 0);
      localparam logic [ADDR_W-1:0] MY_MODE = ADDR_W'(CORE_BASE + i);
      localparam logic [ADDR_W-1:0] MY_STAT = ADDR_W'(STAT_BASE + i);

      logic [VEC_W-1:0] vec_q;
      logic             tcm_q, halt_q;
      rst_cause_t       cause_q;
      logic             sel_we;

      assign sel_we = wr_ok && (addr == MY_MODE);

      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            vec_q  <= '0;
            tcm_q  <= TCM_D;
            halt_q <= HALT_D;
         end else if (dflt) begin
            vec_q  <= '0;
            tcm_q  <= TCM_D;
            halt_q <= HALT_D;
         end else if (sel_we) begin
            vec_q  <= wdata[DATA_W-1:VEC_LSB];
            tcm_q  <= wdata[1];
            halt_q <= wdata[0];
         end
      end

      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)       cause_q <= '{src: RS_PIN, kind: RT_POR};
         else if (cause_we) cause_q <= cause_in;
      end

      always_comb begin
         rd_core[i] = '0;
         if (addr == MY_MODE)
            rd_core[i] = {vec_q, 3'b000, tcm_q, halt_q};
         else if (addr == MY_STAT)
            rd_core[i] = {{(DATA_W-5){1'b0}}, cause_q};
      end

      assign halt_out[i] = halt_all_q | halt_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == '0) begin
         rdata[MB_PMHALT] = pm_halt_q;
         rdata[MB_DDRC]   = ddrc_q;
      end
      for (int k = 0; k < NCORE; k++) rdata = rdata | rd_core[k];
   end

endmodule

// File: rtl/soc_reset_hub.sv
module soc_reset_hub
   import rst_hub_pkg::*;
#(
   parameter int unsigned NCORE       = 4,
   parameter int unsigned STRETCH     = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned FAB_EN_W    = 3,
   parameter logic [15:0] KEY         = 16'hCDEF,
   parameter logic        CORE0_HALT  = 1'b0
) (
   input  logic                clk,
   input  logic                por_pin_n,
   input  logic                sys_pin_n,
   input  logic                pm_mode_pin,
   input  logic [FAB_EN_W-1:0] fab_en,
   input  logic                fab_sys_req_n,
   input  logic                fab_pm_req_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                clkmgr_rst_n,
   output logic                sys_rst_n,
   output logic                fab_rst_n,
   output logic [NCORE-1:0]    core_halt,
   output logic                ddrc_rst
);

   localparam int unsigned NREGS = 1 + 2 * NCORE;

   if (NCORE < 1 || NCORE > 8) begin : g_bad_ncore
      $error("soc_reset_hub: NCORE must be 1..8");
   end
   if (STRETCH < 1) begin : g_bad_stretch
      $error("soc_reset_hub: STRETCH must be at least 1");
   end
   if (NREGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("soc_reset_hub: ADDR_W too small for the register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("soc_reset_hub: SYNC_STAGES must be at least 2");
   end

   logic       pin_act, pin_pm_sel, hit, active, cause_we, dflt, pm_hit;
   logic [2:0] trig;
   rst_type_e  hit_kind, act_kind;
   rst_src_e   hit_src;
   rst_cause_t cause_in;

   rst_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sys (
      .clk(clk), .arst_n(por_pin_n), .d(~sys_pin_n), .q(pin_act));

   rst_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_pm (
      .clk(clk), .arst_n(por_pin_n), .d(pm_mode_pin), .q(pin_pm_sel));

   rst_cause_arb #(.FAB_EN_W(FAB_EN_W)) i_arb (
      .pin_act   (pin_act),
      .pin_pm_sel(pin_pm_sel),
      .reg_trig  (trig),
      .fab_en    (fab_en),
      .fab_sys   (~fab_sys_req_n),
      .fab_pm    (~fab_pm_req_n),
      .hit       (hit),
      .hit_kind  (hit_kind),
      .hit_src   (hit_src));

   rst_stretch #(.STRETCH(STRETCH)) i_stretch (
      .clk        (clk),
      .arst_n     (por_pin_n),
      .hit        (hit),
      .hit_kind   (hit_kind),
      .active     (active),
      .active_kind(act_kind));

   assign cause_we = hit && (!active || (hit_kind <= act_kind));
   assign dflt     = (hit && (hit_kind != RT_PM)) || (active && (act_kind != RT_PM));
   assign pm_hit   = hit && (hit_kind == RT_PM);
   assign cause_in = '{src: hit_src, kind: hit_kind};

   rst_mode_regs #(
      .NCORE(NCORE), .ADDR_W(ADDR_W), .KEY(KEY), .CORE0_HALT(CORE0_HALT)
   ) i_regs (
      .clk     (clk),
      .arst_n  (por_pin_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .wr_block(active),
      .dflt    (dflt),
      .pm_hit  (pm_hit),
      .cause_we(cause_we),
      .cause_in(cause_in),
      .trig    (trig),
      .ddrc    (ddrc_rst),
      .halt_out(core_halt));

   assign sys_rst_n    = ~active;
   assign fab_rst_n    = ~active;
   assign clkmgr_rst_n = ~(active && (act_kind == RT_POR));

endmodule

// File: rtl/soc_reset_hub_chk.sv
module soc_reset_hub_chk #(
   parameter int unsigned STRETCH = 16,
   parameter int unsigned ADDR_W  = 4,
   parameter logic [15:0] KEY     = 16'hCDEF
) (
   input logic              clk,
   input logic              por_pin_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              clkmgr_rst_n,
   input logic              sys_rst_n,
   input logic              fab_rst_n,
   input logic              ddrc_rst
);

   int unsigned lo_cnt;

   always_ff @(posedge clk or negedge por_pin_n) begin
      if (!por_pin_n)      lo_cnt <= 0;
      else if (sys_rst_n)  lo_cnt <= 0;
      else if (lo_cnt < STRETCH + 1) lo_cnt <= lo_cnt + 1;
   end

   assert_clkmgr_inside_sys_R3: assert property (@(posedge clk) disable iff (!por_pin_n)
      !clkmgr_rst_n |-> !sys_rst_n);

   assert_fabric_tracks_R9: assert property (@(posedge clk) disable iff (!por_pin_n)
      !sys_rst_n |-> !fab_rst_n);

   assert_trigger_takes_R11: assert property (@(posedge clk) disable iff (!por_pin_n)
      (sys_rst_n && reg_we && reg_addr == '0 && reg_wdata[31:16] == KEY && |reg_wdata[2:0])
      |=> !sys_rst_n);

   assert_min_width_R11: assert property (@(posedge clk) disable iff (!por_pin_n)
      $rose(sys_rst_n) |-> (lo_cnt >= STRETCH));

   assert_key_reads_zero_R1: assert property (@(posedge clk) disable iff (!por_pin_n)
      (reg_addr == '0) |-> (reg_rdata[31:16] == 16'h0));

   assert_trig_reads_zero_R2: assert property (@(posedge clk) disable iff (!por_pin_n)
      (reg_addr == '0) |-> (reg_rdata[2:0] == 3'b000));

   assert_ddrc_default_R5: assert property (@(posedge clk) disable iff (!por_pin_n)
      !clkmgr_rst_n |-> ddrc_rst);

endmodule

bind soc_reset_hub soc_reset_hub_chk #(.STRETCH(STRETCH), .ADDR_W(ADDR_W), .KEY(KEY)) i_chk (
   .clk(clk), .por_pin_n(por_pin_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clkmgr_rst_n(clkmgr_rst_n),
   .sys_rst_n(sys_rst_n), .fab_rst_n(fab_rst_n), .ddrc_rst(ddrc_rst));

// File: tb/test_soc_reset_hub.sv
`timescale 1ns/1ps
module test_soc_reset_hub;

   localparam int NCORE   = 4;
   localparam int STRETCH = 16;
   localparam int ADDR_W  = 4;
   localparam int STAT0   = 1 + NCORE;

   typedef struct packed {
      logic [31:0] wd;
      logic        we;
      logic [2:0]  fen;
      logic        fsys_n;
      logic        fpm_n;
      logic        exp_sysn;
      logic        exp_clkn;
      logic [4:0]  exp_stat;
   } vec_t;

   // status = {src[2:0], type[1:0]}
   localparam vec_t [0:12] VECS = '{
      '{32'h0000_0002, 1'b1, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 5'd0 },  // R1 unkeyed
      '{32'hCDEF_0002, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 5'd13},  // R2 sys bit
      '{32'hCDEF_0001, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 5'd4 },  // R2 R3 por bit
      '{32'hCDEF_0004, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 5'd18},  // R2 pm bit
      '{32'hCDEF_0007, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b0, 5'd4 },  // R12 por wins
      '{32'hCDEF_0006, 1'b1, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 5'd13},  // R12 sys over pm
      '{32'h0000_0000, 1'b0, 3'b111, 1'b0, 1'b1, 1'b0, 1'b1, 5'd25},  // R7 R8 fabric sys
      '{32'h0000_0000, 1'b0, 3'b110, 1'b0, 1'b1, 1'b1, 1'b1, 5'd25},  // R7 gated off
      '{32'h0000_0000, 1'b0, 3'b111, 1'b1, 1'b0, 1'b0, 1'b1, 5'd26},  // R7 fabric pm
      '{32'h0000_0000, 1'b0, 3'b011, 1'b1, 1'b0, 1'b1, 1'b1, 5'd26},  // R7 gated off
      '{32'hCDEF_0004, 1'b1, 3'b111, 1'b0, 1'b1, 1'b0, 1'b1, 5'd25},  // R12 sys fab over pm reg
      '{32'hCDEF_0002, 1'b1, 3'b111, 1'b0, 1'b1, 1'b0, 1'b1, 5'd13},  // R12 reg over fabric
      '{32'hCDEE_0001, 1'b1, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 5'd13}   // R1 wrong key
   };

   logic              clk = 1'b0;
   logic              por_pin_n, sys_pin_n, pm_mode_pin;
   logic [2:0]        fab_en;
   logic              fab_sys_req_n, fab_pm_req_n, reg_we;
   logic [ADDR_W-1:0] reg_addr;
   logic [31:0]       reg_wdata, reg_rdata;
   logic              clkmgr_rst_n, sys_rst_n, fab_rst_n, ddrc_rst;
   logic [NCORE-1:0]  core_halt;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   soc_reset_hub #(.NCORE(NCORE), .STRETCH(STRETCH), .ADDR_W(ADDR_W)) i_soc_reset_hub (
      .clk(clk), .por_pin_n(por_pin_n), .sys_pin_n(sys_pin_n), .pm_mode_pin(pm_mode_pin),
      .fab_en(fab_en), .fab_sys_req_n(fab_sys_req_n), .fab_pm_req_n(fab_pm_req_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .clkmgr_rst_n(clkmgr_rst_n), .sys_rst_n(sys_rst_n), .fab_rst_n(fab_rst_n),
      .core_halt(core_halt), .ddrc_rst(ddrc_rst));

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = ADDR_W'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic pin_pulse(input logic pm);
      @(negedge clk);
      pm_mode_pin = pm;
      repeat (3) @(negedge clk);
      sys_pin_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3", "clkmgr during pin reset", 32'(clkmgr_rst_n), 32'd1);
      chk("R9", "fabric reset during pin reset", 32'(fab_rst_n), 32'd0);
      sys_pin_n = 1'b1;
      repeat (STRETCH + 6) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int lowc;
      por_pin_n = 1'b0; sys_pin_n = 1'b1; pm_mode_pin = 1'b0; fab_en = 3'b000;
      fab_sys_req_n = 1'b1; fab_pm_req_n = 1'b1; reg_we = 1'b0; reg_addr = '0;
      reg_wdata = '0;

      // reset state
      repeat (3) @(negedge clk);
      chk("R3", "clkmgr in power-on", 32'(clkmgr_rst_n), 32'd0);
      chk("R9", "fabric in power-on", 32'(fab_rst_n), 32'd0);
      por_pin_n = 1'b1;
      @(negedge clk);
      chk("R11", "stretched after pin release", 32'(sys_rst_n), 32'd0);
      repeat (STRETCH + 2) @(negedge clk);
      chk("R11", "released", 32'(sys_rst_n), 32'd1);
      rd(0, d);             chk("R5", "mode default", d, 32'h10);
      chk("R10", "ddrc default", 32'(ddrc_rst), 32'd1);
      rd(1, d);             chk("R5", "core0 default", d, 32'h0);
      rd(2, d);             chk("R5", "core1 default", d, 32'h3);
      chk("R6", "halt default", 32'(core_halt), 32'hE);
      rd(STAT0, d);         chk("R8", "status after pin power-on", d, 32'd0);

      // vector table
      for (int v = 0; v < 13; v++) begin
         @(negedge clk);
         reg_we = VECS[v].we; reg_addr = '0; reg_wdata = VECS[v].wd;
         fab_en = VECS[v].fen; fab_sys_req_n = VECS[v].fsys_n; fab_pm_req_n = VECS[v].fpm_n;
         @(posedge clk);
         @(negedge clk);
         reg_we = 1'b0; fab_en = 3'b000; fab_sys_req_n = 1'b1; fab_pm_req_n = 1'b1;
         chk("R1 R2 R7 R11", "sys_rst_n", 32'(sys_rst_n), 32'(VECS[v].exp_sysn));
         chk("R3", "clkmgr_rst_n", 32'(clkmgr_rst_n), 32'(VECS[v].exp_clkn));
         chk("R9", "fab_rst_n", 32'(fab_rst_n), 32'(VECS[v].exp_sysn));
         rd(STAT0, d);
         chk("R8 R12", "cause", d, 32'(VECS[v].exp_stat));
         repeat (STRETCH + 3) @(negedge clk);
         chk("R11", "release", 32'(sys_rst_n), 32'd1);
      end

      // R1 and R10: key gate and DDR hold
      wr(0, 32'h0000_0008);
      rd(0, d);             chk("R1", "unkeyed write ignored", d, 32'h10);
      wr(0, 32'hCDEF_0008);
      rd(0, d);             chk("R1", "keyed write, key reads zero", d, 32'h08);
      chk("R10", "ddrc released", 32'(ddrc_rst), 32'd0);

      // R6 and R5: per-core halt, post-mortem keeps settings
      wr(1, 32'h0000_0000);
      wr(2, 32'h0000_0020);
      @(negedge clk);
      chk("R6", "per-core halt", 32'(core_halt), 32'hC);
      pin_pulse(1'b1);
      rd(STAT0, d);         chk("R4", "pin post-mortem cause", d, 32'd2);
      chk("R6", "all halted after post-mortem", 32'(core_halt), 32'hF);
      rd(0, d);             chk("R5", "mode kept by post-mortem", d, 32'h08);
      rd(2, d);             chk("R5", "core1 kept by post-mortem", d, 32'h20);
      wr(0, 32'hCDEF_0000);
      repeat (2) @(negedge clk);
      chk("R6", "halt-all cleared", 32'(core_halt), 32'hC);

      // R2: trigger plus halt bit in one keyed write
      wr(0, 32'hCDEF_000C);
      repeat (STRETCH + 3) @(negedge clk);
      rd(0, d);             chk("R2", "trigger bits read zero", d, 32'h08);
      chk("R6", "halt-all from register post-mortem", 32'(core_halt), 32'hF);
      rd(STAT0 + 3, d);     chk("R8", "core3 cause", d, 32'd18);

      // R13: write during reset is dropped
      @(negedge clk);
      wr(0, 32'hCDEF_0002);
      wr(2, 32'h0000_0040);
      repeat (STRETCH + 3) @(negedge clk);
      rd(2, d);             chk("R13", "write during reset ignored", d, 32'h3);

      // R4: system pin with mode 0 restores defaults
      wr(2, 32'h0000_0000);
      pin_pulse(1'b0);
      rd(STAT0, d);         chk("R4", "pin system cause", d, 32'd1);
      rd(0, d);             chk("R5", "mode restored", d, 32'h10);
      rd(2, d);             chk("R5", "core1 restored", d, 32'h3);
      chk("R6", "halt after system", 32'(core_halt), 32'hE);

      // R11: exact width
      lowc = 0;
      wr(0, 32'hCDEF_0002);
      for (int k = 0; k < STRETCH + 4; k++) begin
         if (!sys_rst_n) lowc++;
         @(negedge clk);
      end
      chk("R11", "register reset width", 32'(lowc), 32'(STRETCH));

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule